// File: doc/BRIEF.md
# Oversampled Symbol Timing Phase Estimator

This block watches a stream of complex baseband samples taken three times per symbol and decides which of the three sample slots lies closest to the symbol centre. Each accepted sample carries an in-phase and a quadrature component and a valid flag. The block squares the magnitude of every sample and adds it to a running sum kept for the slot that sample belongs to. It uses only magnitude, so the result does not depend on carrier phase or frequency offset.

When a window of `WIN_SYMS` symbols is complete, the slot with the largest sum becomes the timing index. The block compares that index with the one from the previous window. If the winning slot moved one step back, the transmitter runs faster than the receiver and a sample must be added downstream, so the block raises a one-cycle shortage pulse. If it moved one step forward, the transmitter runs slower and a sample must be dropped, so the block raises a surplus pulse.

A burst-start input clears all running sums and the slot counter. The first window after a burst start only sets the initial index and raises no event. The estimate is purely feedforward: nothing has to converge, and the decision comes a fixed one cycle after the last sample of a window.

Top module: `sym_timing_est`

## Requirements
- R1: The energy of a sample is inI*inI + inQ*inQ, with both inputs read as signed two's complement. A sample whose components are negated or swapped adds the same amount.
- R2: Only cycles with inValid high take part. The slot counter starts at 0 after reset or burst start, advances 0,1,2,0 on each accepted sample, and a window ends after 3*WIN_SYMS accepted samples.
- R3: The per-slot sums hold WIN_SYMS full-scale samples (both components at -2^(SAMPLE_W-1)) without wrapping.
- R4: timingIdx (0..2) takes the slot with the largest sum. It and idxValid update on the clock edge after the edge that accepts a window's last sample.
- R5: A change of the index 0→2, 1→0 or 2→1 raises shortagePulse for exactly one cycle, on the same edge as the index update.
- R6: A change of the index 0→1, 1→2 or 2→0 raises surplusPulse for exactly one cycle, on the same edge as the index update.
- R7: If the winning slot equals the current index, no pulse is raised. A slot whose sum only ties with the current index's sum does not replace it.
- R8: burstStart clears the sums, the counters and idxValid on the next edge, and discards a sample presented in the same cycle. The first window after it sets timingIdx and raises no pulse.
- R9: After reset, idxValid, shortagePulse, surplusPulse and timingIdx are all 0.
- R10: When there is no current index (the first window), a tie between slots resolves to the lowest slot number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| burstStart | input | 1 | Starts a new burst: clears sums, counters and the index |
| inValid | input | 1 | Sample on inI/inQ is valid this cycle |
| inI | input | SAMPLE_W | In-phase component, signed |
| inQ | input | SAMPLE_W | Quadrature component, signed |
| timingIdx | output | 2 | Current symbol timing slot |
| idxValid | output | 1 | timingIdx holds a decision made since the last burst start |
| shortagePulse | output | 1 | One-cycle pulse: the transmitter is faster, so insert a sample |
| surplusPulse | output | 1 | One-cycle pulse: the transmitter is slower, so drop a sample |

## Verification
A sequence of windows, each with one dominant slot, walks the index through every backward step, every forward step and every unchanged case. This separates shortage from surplus and confirms that pulses appear only on a move. The dominant samples use negative, swapped and rotated components, so a design that ignores the sign or one of the components picks the wrong slot. Directed patterns cover the rest: windows of equal energy, which tell the tie rule for a held index apart from the tie rule for the first window; full-scale windows, which would wrap a narrow sum; gaps in inValid inside a window; and a burst start in the middle of a window, which shows whether old energy and an old index leak into the new burst.

// File: rtl/sym_timing_pkg.sv
package sym_timing_pkg;
  localparam int TS_PHASES  = 3;
  localparam int TS_PHASE_W = $clog2(TS_PHASES);

  typedef struct packed {
    logic                  clear;
    logic                  accEn;
    logic                  winEnd;
    logic [TS_PHASE_W-1:0] phase;
  } ts_ctl_t;
endpackage

// File: rtl/sym_timing_datapath.sv
module sym_timing_datapath
  import sym_timing_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int WIN_SYMS = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ts_ctl_t               ctl,
  input  logic [SAMPLE_W-1:0]   inI,
  input  logic [SAMPLE_W-1:0]   inQ,
  input  logic [TS_PHASE_W-1:0] curIdx,
  input  logic                  haveIdx,
  output logic [TS_PHASE_W-1:0] winIdx
);
  localparam int SQ_W  = 2 * SAMPLE_W;
  localparam int EN_W  = SQ_W + 1;
  localparam int ACC_W = EN_W + $clog2(WIN_SYMS + 1);

  logic signed [SQ_W-1:0] sqI, sqQ;
  logic [EN_W-1:0]        energy;

  assign sqI    = $signed(inI) * $signed(inI);
  assign sqQ    = $signed(inQ) * $signed(inQ);
  assign energy = EN_W'($unsigned(sqI)) + EN_W'($unsigned(sqQ));

  logic [ACC_W-1:0] acc  [TS_PHASES];
  logic [ACC_W-1:0] snap [TS_PHASES];

  for (genvar g = 0; g < TS_PHASES; g++) begin : g_slot
    logic hit;
    assign hit = (ctl.phase == TS_PHASE_W'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        acc[g]  <= '0;
        snap[g] <= '0;
      end else if (ctl.clear) begin
        acc[g] <= '0;
      end else if (ctl.accEn) begin
        if (ctl.winEnd) begin
          acc[g]  <= '0;
          snap[g] <= acc[g] + (hit ? ACC_W'(energy) : '0);
        end else if (hit) begin
          acc[g] <= acc[g] + ACC_W'(energy);
        end
      end
    end
  end

  // Argmax: the current index wins ties; otherwise the lowest slot wins.
  always_comb begin
    logic [ACC_W-1:0] best;
    winIdx = haveIdx ? curIdx : '0;
    best   = snap[winIdx];
    for (int m = 0; m < TS_PHASES; m++) begin
      if (snap[m] > best) begin
        best   = snap[m];
        winIdx = TS_PHASE_W'(m);
      end
    end
  end
endmodule

// File: rtl/sym_timing_control.sv
module sym_timing_control
  import sym_timing_pkg::*;
#(
  parameter int WIN_SYMS = 64
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  burstStart,
  input  logic                  inValid,
  input  logic [TS_PHASE_W-1:0] winIdx,
  output ts_ctl_t               ctl,
  output logic [TS_PHASE_W-1:0] curIdx,
  output logic                  haveIdx,
  output logic                  shortagePulse,
  output logic                  surplusPulse
);
  localparam int SYM_W = $clog2(WIN_SYMS + 1);
  localparam logic [TS_PHASE_W-1:0] LAST_PH = TS_PHASE_W'(TS_PHASES - 1);
  localparam logic [SYM_W-1:0]      LAST_SY = SYM_W'(WIN_SYMS - 1);

  logic [TS_PHASE_W-1:0] phaseCnt;
  logic [SYM_W-1:0]      symCnt;
  logic                  decidePend;
  logic [TS_PHASE_W-1:0] backIdx, fwdIdx;

  assign ctl.clear  = burstStart;
  assign ctl.accEn  = inValid && !burstStart;
  assign ctl.winEnd = ctl.accEn && (phaseCnt == LAST_PH) && (symCnt == LAST_SY);
  assign ctl.phase  = phaseCnt;

  assign backIdx = (curIdx == '0) ? LAST_PH : curIdx - 1'b1;
  assign fwdIdx  = (curIdx == LAST_PH) ? '0 : curIdx + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt      <= '0;
      symCnt        <= '0;
      decidePend    <= 1'b0;
      curIdx        <= '0;
      haveIdx       <= 1'b0;
      shortagePulse <= 1'b0;
      surplusPulse  <= 1'b0;
    end else if (burstStart) begin
      phaseCnt      <= '0;
      symCnt        <= '0;
      decidePend    <= 1'b0;
      curIdx        <= '0;
      haveIdx       <= 1'b0;
      shortagePulse <= 1'b0;
      surplusPulse  <= 1'b0;
    end else begin
      shortagePulse <= 1'b0;
      surplusPulse  <= 1'b0;
      decidePend    <= ctl.winEnd;
      if (ctl.accEn) begin
        if (phaseCnt == LAST_PH) begin
          phaseCnt <= '0;
          symCnt   <= (symCnt == LAST_SY) ? '0 : symCnt + 1'b1;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end
      if (decidePend) begin
        curIdx  <= winIdx;
        haveIdx <= 1'b1;
        if (haveIdx && winIdx != curIdx) begin
          shortagePulse <= (winIdx == backIdx);
          surplusPulse  <= (winIdx == fwdIdx);
        end
      end
    end
  end
endmodule

// File: rtl/sym_timing_est.sv
module sym_timing_est
  import sym_timing_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int WIN_SYMS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                burstStart,
  input  logic                inValid,
  input  logic [SAMPLE_W-1:0] inI,
  input  logic [SAMPLE_W-1:0] inQ,
  output logic [1:0]          timingIdx,
  output logic                idxValid,
  output logic                shortagePulse,
  output logic                surplusPulse
);
  ts_ctl_t               ctl;
  logic [TS_PHASE_W-1:0] winIdx;
  logic [TS_PHASE_W-1:0] curIdx;
  logic                  haveIdx;

  sym_timing_control #(.WIN_SYMS(WIN_SYMS)) u_ctl (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .inValid(inValid),
    .winIdx(winIdx), .ctl(ctl), .curIdx(curIdx), .haveIdx(haveIdx),
    .shortagePulse(shortagePulse), .surplusPulse(surplusPulse)
  );

  sym_timing_datapath #(.SAMPLE_W(SAMPLE_W), .WIN_SYMS(WIN_SYMS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .inI(inI), .inQ(inQ),
    .curIdx(curIdx), .haveIdx(haveIdx), .winIdx(winIdx)
  );

  assign timingIdx = 2'(curIdx);
  assign idxValid  = haveIdx;
endmodule

// File: rtl/sym_timing_est_checker.sv
module sym_timing_est_checker (
  input logic       clk,
  input logic       rstN,
  input logic       burstStart,
  input logic [1:0] timingIdx,
  input logic       idxValid,
  input logic       shortagePulse,
  input logic       surplusPulse
);
  p_idx_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    timingIdx < 2'd3);

  p_pulse_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(shortagePulse && surplusPulse));

  p_short_once_r5: assert property (@(posedge clk) disable iff (!rstN)
    shortagePulse |=> !shortagePulse);

  p_surp_once_r6: assert property (@(posedge clk) disable iff (!rstN)
    surplusPulse |=> !surplusPulse);

  p_short_dir_r5: assert property (@(posedge clk) disable iff (!rstN)
    shortagePulse |-> timingIdx == (($past(timingIdx) == 2'd0) ? 2'd2 : $past(timingIdx) - 2'd1));

  p_surp_dir_r6: assert property (@(posedge clk) disable iff (!rstN)
    surplusPulse |-> timingIdx == (($past(timingIdx) == 2'd2) ? 2'd0 : $past(timingIdx) + 2'd1));

  p_event_moves_r7: assert property (@(posedge clk) disable iff (!rstN)
    (shortagePulse || surplusPulse) |-> (idxValid && $past(idxValid) && timingIdx != $past(timingIdx)));

  p_burst_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    burstStart |=> (!idxValid && !shortagePulse && !surplusPulse));
endmodule

bind sym_timing_est sym_timing_est_checker u_chk (
  .clk(clk), .rstN(rstN), .burstStart(burstStart), .timingIdx(timingIdx),
  .idxValid(idxValid), .shortagePulse(shortagePulse), .surplusPulse(surplusPulse)
);

// File: tb/sym_timing_est_test.sv
`timescale 1ns/1ps
module sym_timing_est_test;
  localparam int SW  = 8;
  localparam int WIN = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic burstStart = 1'b0;
  logic inValid = 1'b0;
  logic [SW-1:0] inI = '0, inQ = '0;
  logic [1:0] timingIdx;
  logic idxValid, shortagePulse, surplusPulse;

  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk;

  sym_timing_est #(.SAMPLE_W(SW), .WIN_SYMS(WIN)) uut (
    .clk(clk), .rstN(rstN), .burstStart(burstStart), .inValid(inValid),
    .inI(inI), .inQ(inQ), .timingIdx(timingIdx), .idxValid(idxValid),
    .shortagePulse(shortagePulse), .surplusPulse(surplusPulse)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One sample per call, driven after the falling edge.
  task automatic putSample(input int i, input int q);
    @(negedge clk);
    inValid = 1'b1;
    inI = SW'(i);
    inQ = SW'(q);
  endtask

  // A window whose hot slot carries rotating large samples; other slots are small.
  task automatic sendWindow(input int hot);
    for (int s = 0; s < WIN; s++) begin
      for (int p = 0; p < 3; p++) begin
        if (p == hot) begin
          case (s % 4)
            0: putSample(-100, 50);
            1: putSample(50, -100);
            2: putSample(100, -50);
            default: putSample(-50, 100);
          endcase
        end else begin
          putSample(20, -10);
        end
      end
    end
  endtask

  // After the last sample: one edge captures it, the next publishes the decision.
  task automatic settle();
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic checkDecision(input string req, input int expIdx, input bit expSh, input bit expSu);
    chk(idxValid === 1'b1, {req, " idxValid"}, int'(idxValid), 1);
    chk(timingIdx === 2'(expIdx), {req, " timingIdx"}, int'(timingIdx), expIdx);
    chk(shortagePulse === expSh, {req, " shortagePulse"}, int'(shortagePulse), int'(expSh));
    chk(surplusPulse === expSu, {req, " surplusPulse"}, int'(surplusPulse), int'(expSu));
    @(negedge clk);
    chk(!shortagePulse && !surplusPulse, {req, " pulse one cycle"},
        int'({shortagePulse, surplusPulse}), 0);
  endtask

  task automatic pulseBurst();
    @(negedge clk);
    inValid = 1'b0;
    burstStart = 1'b1;
    @(negedge clk);
    burstStart = 1'b0;
  endtask

  // Vector fields: {hot[1:0], expIdx[1:0], expShortage, expSurplus}
  localparam logic [5:0] VEC [9] = '{
    {2'd0, 2'd0, 1'b0, 1'b0},  // first window: sets index, no event (R8)
    {2'd0, 2'd0, 1'b0, 1'b0},  // unchanged (R7)
    {2'd2, 2'd2, 1'b1, 1'b0},  // 0->2 shortage (R5)
    {2'd1, 2'd1, 1'b1, 1'b0},  // 2->1 shortage (R5)
    {2'd1, 2'd1, 1'b0, 1'b0},  // unchanged (R7)
    {2'd2, 2'd2, 1'b0, 1'b1},  // 1->2 surplus (R6)
    {2'd0, 2'd0, 1'b0, 1'b1},  // 2->0 surplus (R6)
    {2'd1, 2'd1, 1'b0, 1'b1},  // 0->1 surplus (R6)
    {2'd0, 2'd0, 1'b1, 1'b0}   // 1->0 shortage (R5)
  };

  initial begin
    repeat (3) @(negedge clk);
    chk(!idxValid && !shortagePulse && !surplusPulse && timingIdx == 2'd0, "R9 reset state",
        int'({idxValid, shortagePulse, surplusPulse, timingIdx}), 0);
    rstN = 1'b1;
    pulseBurst();

    // Table walk (R1, R2, R4, R5, R6, R7, R8)
    foreach (VEC[v]) begin
      sendWindow(int'(VEC[v][5:4]));
      settle();
      checkDecision($sformatf("R4/R5/R6 vec%0d", v), int'(VEC[v][3:2]), VEC[v][1], VEC[v][0]);
    end

    // R7: equal energy in all slots keeps index 0, no event
    for (int s = 0; s < 3 * WIN; s++) putSample(30, 40);
    settle();
    checkDecision("R7 tie holds index", 0, 1'b0, 1'b0);

    // Move to index 2, then tie: the index must stay at 2 (R7)
    sendWindow(2);
    settle();
    checkDecision("R5 move to 2", 2, 1'b1, 1'b0);
    for (int s = 0; s < 3 * WIN; s++) putSample(-40, 30);
    settle();
    checkDecision("R7 tie holds index 2", 2, 1'b0, 1'b0);

    // R2: gaps in inValid inside a window do not advance the slot
    for (int s = 0; s < WIN; s++) begin
      putSample(20, 10);
      @(negedge clk); inValid = 1'b0; inI = SW'(127); inQ = SW'(127);
      putSample(-110, -60);
      putSample(20, 10);
    end
    settle();
    checkDecision("R2 gaps ignored", 1, 1'b1, 1'b0);

    // R8: burst start mid-window drops old energy and index
    pulseBurst();
    chk(!idxValid, "R8 idxValid cleared", int'(idxValid), 0);
    for (int s = 0; s < 40; s++) begin
      putSample(5, 5); putSample(5, 5); putSample(120, 120);
    end
    // burst start with a sample in the same cycle: that sample is discarded
    @(negedge clk);
    burstStart = 1'b1; inValid = 1'b1; inI = SW'(127); inQ = SW'(127);
    @(negedge clk);
    burstStart = 1'b0; inValid = 1'b0;
    // R10: first window all equal -> lowest slot, no event
    for (int s = 0; s < 3 * WIN; s++) putSample(-60, 60);
    settle();
    checkDecision("R8/R10 first window tie to slot 0", 0, 1'b0, 1'b0);

    // R3: full scale on slot 1 vs near full scale elsewhere
    for (int s = 0; s < WIN; s++) begin
      putSample(127, 127); putSample(-128, -128); putSample(127, -127);
    end
    settle();
    checkDecision("R3 full scale no wrap", 1, 1'b0, 1'b1);

    // R8: after a burst start the first window sets the index with no event
    pulseBurst();
    sendWindow(2);
    settle();
    checkDecision("R8 first window no event", 2, 1'b0, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule